// File: doc/BRIEF.md
# Calendar Alarm Comparator and Periodic Tick Interrupt

This block sits next to a BCD calendar counter. It holds one alarm byte per time field (seconds, minutes, hours, weekday, day of month, month, year). Each field takes part in the comparison only while its own enable bit is set. When every enabled field equals the running time, the block raises an alarm flag. It also divides a 256 Hz sub-second strobe into a periodic event whose rate comes from a code in the control register, and it latches a carry event reported by the counter.

Software reaches the block over a byte-wide register bus with write-only strobes and a combinational read port. Each flag sits in the status register at the same bit position as its enable in the control register. A write of 0 clears a flag and a write of 1 leaves it alone. Each interrupt line is the AND of a flag and its enable. A write to any alarm byte blanks new alarm flags until the match settles. The blanking ends after two internal 1/64 s ticks.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, all alarm bytes, the control register and the status register read 0, and all three interrupt lines are low.
- R2: The alarm bytes live at even addresses. Seconds is at 0x10, minutes 0x12, hours 0x14, weekday 0x16, day 0x18, month 0x1A, year 0x1C, and the year enable byte is at 0x1E. Each reads back the full byte written. A write to an odd address in that range changes none of them.
- R3: A field is enabled by bit 7 of its alarm byte, and the year field by bit 7 of the byte at 0x1E. An enabled field matches when its value bits are equal: bits 6:0 for seconds and minutes, bits 6:0 for hours (bit 6 is the PM bit), bits 2:0 for weekday, 5:0 for day, 4:0 for month and 7:0 for year. A disabled field always matches. With no field enabled there is never a match.
- R4: The alarm flag (status bit 0) sets at the clock edge that ends the first cycle of a match, that is, when a match is present and was absent in the previous cycle. It does not set again while the match persists.
- R5: After any write to an alarm byte, a match edge sets no alarm flag until two 1/64 s ticks have passed. A tick is every fourth sub-second strobe of the free-running divider.
- R6: The control register at 0x22 selects the periodic rate in bits 7:4. A code c from 6 to 15 gives one event every 2^(c-6) sub-second strobes, so code 0x8 gives one every 4 strobes (1/64 s). Codes below 6 give no events. Each event sets the periodic flag (status bit 2).
- R7: A carry event pulse sets the carry flag (status bit 1).
- R8: The status register is at 0x20. A write of 0 to a flag bit clears that flag and a write of 1 leaves it unchanged. Bits 7:3 read 0.
- R9: When a flag's set event and a clearing write fall in the same cycle, the flag ends up set.
- R10: The alarm, carry and periodic interrupt lines each equal their flag ANDed with control bits 0, 1 and 2 respectively.
- R11: The control register reads back its enables in bits 2:0 and its rate code in bits 7:4. Bit 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick_i | input | 1 | One-cycle 256 Hz sub-second strobe |
| carry_evt_i | input | 1 | One-cycle carry event from the counter |
| now_sec_i | input | 7 | Current seconds, BCD |
| now_min_i | input | 7 | Current minutes, BCD |
| now_hour_i | input | 7 | Current hours, BCD, bit 6 is PM |
| now_wday_i | input | 3 | Current weekday |
| now_day_i | input | 6 | Current day of month, BCD |
| now_mon_i | input | 5 | Current month, BCD |
| now_year_i | input | 8 | Current year, BCD |
| bus_wen_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| status_o | output | 3 | Flags: alarm, carry, periodic (bits 0,1,2) |
| irq_alarm_o | output | 1 | Alarm interrupt |
| irq_carry_o | output | 1 | Carry interrupt |
| irq_period_o | output | 1 | Periodic interrupt |

## Verification
A hardware set event and a software clearing write can land in the same cycle: a carry pulse, a periodic event or an alarm edge meeting a status write that carries a 0. The bench forces this directly, pulsing the carry input during a clear-all write. The random phase also overlaps status writes with sub-second strobes and match edges. In both cases the bench compares the flags after the edge against its own model, in which a set beats a clear. The second collision is an alarm-byte write that meets a 1/64 s tick. Here the write must restart the settling window, and the model checks this each cycle.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int ADDR_W     = 6;
    localparam int SEL_W      = 4;
    localparam int N_FIELDS   = 7;
    localparam int N_ALM_REGS = 8;
    localparam int N_FLAGS    = 3;
    localparam int YEAR_IDX   = 6;
    localparam int YEAR_EN_IDX = 7;

    localparam logic [ADDR_W-1:0] ADDR_ALM_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 6'h20;
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 6'h22;

    localparam int FLAG_ALARM  = 0;
    localparam int FLAG_CARRY  = 1;
    localparam int FLAG_PERIOD = 2;

    // Value bits that take part in each field's comparison.
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            0, 1, 2: return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
(
    input  logic [N_ALM_REGS-1:0][7:0] alm_i,
    input  logic [N_FIELDS-1:0][7:0]   now_i,
    output logic                       match_o
);
    logic [N_FIELDS-1:0] field_en;
    logic [N_FIELDS-1:0] field_hit;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        localparam logic [7:0] MASK = field_mask(i);
        if (i == YEAR_IDX) begin : g_year
            assign field_en[i] = alm_i[YEAR_EN_IDX][7];
        end else begin : g_plain
            assign field_en[i] = alm_i[i][7];
        end
        assign field_hit[i] = !field_en[i] || (((now_i[i] ^ alm_i[i]) & MASK) == 8'h00);
    end

    // A match needs at least one field taking part.
    assign match_o = (|field_en) && (&field_hit);
endmodule

// File: rtl/cal_period_gen.sv
module cal_period_gen
    import cal_alarm_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int BASE_CODE  = 6,
    parameter int GUARD_CODE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             per_evt_o,
    output logic             guard_tick_o
);
    localparam int GUARD_SPAN = GUARD_CODE - BASE_CODE;
    localparam logic [DIV_W-1:0] GUARD_MASK = DIV_W'((1 << GUARD_SPAN) - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [SEL_W-1:0] span;
    logic             sel_ok;
    logic [DIV_W-1:0] sel_mask;

    assign sel_ok = (sel_i >= SEL_W'(BASE_CODE)) &&
                    ((sel_i - SEL_W'(BASE_CODE)) < SEL_W'(DIV_W));
    assign span   = sel_i - SEL_W'(BASE_CODE);

    for (genvar k = 0; k < DIV_W; k++) begin : g_mask
        assign sel_mask[k] = (SEL_W'(k) < span);
    end

    always_comb begin
        cnt_d        = cnt_q;
        if (sub_tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
        per_evt_o    = sub_tick_i && sel_ok && ((cnt_q & sel_mask) == sel_mask);
        guard_tick_o = sub_tick_i && ((cnt_q & GUARD_MASK) == GUARD_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int GUARD_TICKS = 2,
    parameter int DIV_W       = 10,
    parameter int BASE_CODE   = 6,
    parameter int GUARD_CODE  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sub_tick_i,
    input  logic        carry_evt_i,
    input  logic [6:0]  now_sec_i,
    input  logic [6:0]  now_min_i,
    input  logic [6:0]  now_hour_i,
    input  logic [2:0]  now_wday_i,
    input  logic [5:0]  now_day_i,
    input  logic [4:0]  now_mon_i,
    input  logic [7:0]  now_year_i,
    input  logic        bus_wen_i,
    input  logic [5:0]  bus_addr_i,
    input  logic [7:0]  bus_wdata_i,
    output logic [7:0]  bus_rdata_o,
    output logic [2:0]  status_o,
    output logic        irq_alarm_o,
    output logic        irq_carry_o,
    output logic        irq_period_o
);
    localparam int GUARD_W = $clog2(GUARD_TICKS + 1);
    localparam int SLOT_W  = $clog2(N_ALM_REGS);
    localparam logic [ADDR_W-1:0] ALM_END = ADDR_ALM_BASE + ADDR_W'(2 * N_ALM_REGS);

    typedef struct packed {
        logic [N_ALM_REGS-1:0][7:0] alm;
        logic [N_FLAGS-1:0]         ctrl_en;
        logic [SEL_W-1:0]           ctrl_sel;
        logic [N_FLAGS-1:0]         flags;
        logic [GUARD_W-1:0]         guard;
        logic                       match_prev;
    } state_t;

    state_t st_d, st_q;

    logic [N_FIELDS-1:0][7:0] now_bank;
    logic                     match_w;
    logic                     per_evt_w;
    logic                     guard_tick_w;
    logic                     guard_idle_w;
    logic [N_FLAGS-1:0]       ctrl_en_w;
    logic                     alm_hit;
    logic [ADDR_W-1:0]        alm_off;
    logic [SLOT_W-1:0]        alm_slot;
    logic                     alm_wr, stat_wr, ctrl_wr;
    logic [N_FLAGS-1:0]       flag_set, flag_keep;

    assign now_bank = {now_year_i, {3'b000, now_mon_i}, {2'b00, now_day_i},
                       {5'b00000, now_wday_i}, {1'b0, now_hour_i},
                       {1'b0, now_min_i}, {1'b0, now_sec_i}};

    cal_alarm_cmp u_cmp (
        .alm_i   (st_q.alm),
        .now_i   (now_bank),
        .match_o (match_w)
    );

    cal_period_gen #(
        .DIV_W      (DIV_W),
        .BASE_CODE  (BASE_CODE),
        .GUARD_CODE (GUARD_CODE)
    ) u_per (
        .clk          (clk),
        .rst_n        (rst_n),
        .sub_tick_i   (sub_tick_i),
        .sel_i        (st_q.ctrl_sel),
        .per_evt_o    (per_evt_w),
        .guard_tick_o (guard_tick_w)
    );

    assign alm_off  = bus_addr_i - ADDR_ALM_BASE;
    assign alm_slot = alm_off[SLOT_W:1];
    assign alm_hit  = (bus_addr_i >= ADDR_ALM_BASE) && (bus_addr_i < ALM_END) && !bus_addr_i[0];
    assign alm_wr   = bus_wen_i && alm_hit;
    assign stat_wr  = bus_wen_i && (bus_addr_i == ADDR_STATUS);
    assign ctrl_wr  = bus_wen_i && (bus_addr_i == ADDR_CTRL);
    assign guard_idle_w = (st_q.guard == '0);
    assign ctrl_en_w    = st_q.ctrl_en;

    always_comb begin
        st_d = st_q;

        if (alm_wr) begin
            st_d.alm[alm_slot] = bus_wdata_i;
        end
        if (ctrl_wr) begin
            st_d.ctrl_en  = bus_wdata_i[N_FLAGS-1:0];
            st_d.ctrl_sel = bus_wdata_i[7:8-SEL_W];
        end

        flag_set              = '0;
        flag_set[FLAG_ALARM]  = match_w && !st_q.match_prev && guard_idle_w;
        flag_set[FLAG_CARRY]  = carry_evt_i;
        flag_set[FLAG_PERIOD] = per_evt_w;
        flag_keep             = stat_wr ? bus_wdata_i[N_FLAGS-1:0] : '1;
        st_d.flags            = (st_q.flags & flag_keep) | flag_set;

        if (alm_wr) begin
            st_d.guard = GUARD_W'(GUARD_TICKS);
        end else if (guard_tick_w && !guard_idle_w) begin
            st_d.guard = st_q.guard - 1'b1;
        end

        st_d.match_prev = match_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = 8'h00;
        if (bus_addr_i == ADDR_STATUS) begin
            bus_rdata_o[N_FLAGS-1:0] = st_q.flags;
        end else if (bus_addr_i == ADDR_CTRL) begin
            bus_rdata_o[N_FLAGS-1:0] = st_q.ctrl_en;
            bus_rdata_o[7:8-SEL_W]   = st_q.ctrl_sel;
        end else if (alm_hit) begin
            bus_rdata_o = st_q.alm[alm_slot];
        end
    end

    assign status_o     = st_q.flags;
    assign irq_alarm_o  = st_q.flags[FLAG_ALARM]  & st_q.ctrl_en[FLAG_ALARM];
    assign irq_carry_o  = st_q.flags[FLAG_CARRY]  & st_q.ctrl_en[FLAG_CARRY];
    assign irq_period_o = st_q.flags[FLAG_PERIOD] & st_q.ctrl_en[FLAG_PERIOD];
endmodule

// File: rtl/cal_alarm_unit_chk.sv
module cal_alarm_unit_chk
    import cal_alarm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wen_i,
    input logic [5:0]  bus_addr_i,
    input logic [7:0]  bus_wdata_i,
    input logic        carry_evt_i,
    input logic [2:0]  status_o,
    input logic        irq_alarm_o,
    input logic        irq_carry_o,
    input logic        irq_period_o,
    input logic        match_w,
    input logic        per_evt_w,
    input logic        guard_idle_w,
    input logic [2:0]  ctrl_en_w
);
    p_alarm_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> $past(match_w));

    p_alarm_after_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> $past(guard_idle_w));

    p_period_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[2]) |-> $past(per_evt_w));

    p_carry_needs_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> $past(carry_evt_i));

    p_alarm_fall_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> $past(bus_wen_i && bus_addr_i == ADDR_STATUS && !bus_wdata_i[0]));

    p_carry_fall_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[1]) |-> $past(bus_wen_i && bus_addr_i == ADDR_STATUS && !bus_wdata_i[1]));

    p_period_fall_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[2]) |-> $past(bus_wen_i && bus_addr_i == ADDR_STATUS && !bus_wdata_i[2]));

    p_carry_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_evt_i |=> status_o[1]);

    p_irq_alarm_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_alarm_o |-> (status_o[0] && ctrl_en_w[0]));

    p_irq_carry_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_carry_o |-> (status_o[1] && ctrl_en_w[1]));

    p_irq_period_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_period_o |-> (status_o[2] && ctrl_en_w[2]));
endmodule

bind cal_alarm_unit cal_alarm_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wen_i    (bus_wen_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .carry_evt_i  (carry_evt_i),
    .status_o     (status_o),
    .irq_alarm_o  (irq_alarm_o),
    .irq_carry_o  (irq_carry_o),
    .irq_period_o (irq_period_o),
    .match_w      (match_w),
    .per_evt_w    (per_evt_w),
    .guard_idle_w (guard_idle_w),
    .ctrl_en_w    (ctrl_en_w)
);

// File: tb/cal_alarm_unit_tb_top.sv
module cal_alarm_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       carry_evt = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
    logic [2:0] now_wday = '0;
    logic [5:0] now_day = '0;
    logic [4:0] now_mon = '0;
    logic [7:0] now_year = '0;
    logic       bus_wen = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] status;
    logic       irq_alarm, irq_carry, irq_period;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    logic [7:0] m_alm [8];
    logic [2:0] m_en = '0;
    logic [3:0] m_sel = '0;
    logic [2:0] m_flags = '0;
    int         m_guard = 0;
    bit         m_mprev = 1'b0;
    int         m_sub = 0;

    always #5 clk = ~clk;

    cal_alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .sub_tick_i(sub_tick), .carry_evt_i(carry_evt),
        .now_sec_i(now_sec), .now_min_i(now_min), .now_hour_i(now_hour),
        .now_wday_i(now_wday), .now_day_i(now_day), .now_mon_i(now_mon),
        .now_year_i(now_year), .bus_wen_i(bus_wen), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .status_o(status),
        .irq_alarm_o(irq_alarm), .irq_carry_o(irq_carry), .irq_period_o(irq_period)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_match();
        logic [7:0] nv [7];
        logic [7:0] mk [7];
        bit any = 1'b0;
        bit ok = 1'b1;
        bit en;
        nv = '{{1'b0, now_sec}, {1'b0, now_min}, {1'b0, now_hour}, {5'b0, now_wday},
               {2'b0, now_day}, {3'b0, now_mon}, now_year};
        mk = '{8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
        for (int i = 0; i < 7; i++) begin
            en = (i == 6) ? m_alm[7][7] : m_alm[i][7];
            if (en) begin
                any = 1'b1;
                if (((nv[i] ^ m_alm[i]) & mk[i]) != 8'h00) ok = 1'b0;
            end
        end
        return any && ok;
    endfunction

    task automatic step(input bit wen, input logic [5:0] a, input logic [7:0] d,
                        input bit sub, input bit cy);
        bit mt, t64, pev, alw;
        int span, msk;
        logic [2:0] set, keep;
        bus_wen = wen; bus_addr = a; bus_wdata = d; sub_tick = sub; carry_evt = cy;
        mt  = exp_match();
        t64 = sub && ((m_sub & 3) == 3);
        pev = 1'b0;
        if (m_sel >= 4'd6) begin
            span = int'(m_sel) - 6;
            msk  = (1 << span) - 1;
            pev  = sub && ((m_sub & msk) == msk);
        end
        alw  = wen && (a >= 6'h10) && (a <= 6'h1E) && !a[0];
        set  = {pev, cy, mt && !m_mprev && (m_guard == 0)};
        keep = (wen && a == 6'h20) ? d[2:0] : 3'b111;
        @(posedge clk); #1;
        m_flags = (m_flags & keep) | set;
        if (alw) begin
            m_alm[(int'(a) - 16) / 2] = d;
            m_guard = 2;
        end else if (t64 && m_guard > 0) begin
            m_guard--;
        end
        if (wen && a == 6'h22) begin
            m_en  = d[2:0];
            m_sel = d[7:4];
        end
        m_mprev = mt;
        m_sub   = (m_sub + int'(sub)) % 1024;
        bus_wen = 1'b0; sub_tick = 1'b0; carry_evt = 1'b0;
        chk("R4 alarm flag", 32'(status[0]), 32'(m_flags[0]));
        chk("R7 carry flag", 32'(status[1]), 32'(m_flags[1]));
        chk("R6 periodic flag", 32'(status[2]), 32'(m_flags[2]));
        chk("R10 alarm irq", 32'(irq_alarm), 32'(m_flags[0] & m_en[0]));
        chk("R10 carry irq", 32'(irq_carry), 32'(m_flags[1] & m_en[1]));
        chk("R10 periodic irq", 32'(irq_period), 32'(m_flags[2] & m_en[2]));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 6'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic settle();
        for (int i = 0; i < 8; i++) step(1'b0, 6'h00, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] tgt [7];
        for (int i = 0; i < 8; i++) m_alm[i] = 8'h00;
        tgt = '{8'h30, 8'h45, 8'h51, 8'h03, 8'h15, 8'h07, 8'h24};
        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1: reset state
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 irqs", 32'({irq_alarm, irq_carry, irq_period}), 32'h0);
        rd(6'h10, v); chk("R1 seconds alarm", 32'(v), 32'h0);
        rd(6'h1E, v); chk("R1 year enable", 32'(v), 32'h0);
        rd(6'h22, v); chk("R1 control", 32'(v), 32'h0);

        // R2: register map and readback, odd address ignored
        for (int i = 0; i < 8; i++) wr(6'(16 + 2 * i), 8'(8'h11 * (i + 1)) & 8'h7F);
        for (int i = 0; i < 8; i++) begin
            rd(6'(16 + 2 * i), v);
            chk("R2 alarm byte readback", 32'(v), 32'((8'h11 * (i + 1)) & 8'h7F));
        end
        wr(6'h11, 8'hEE);
        rd(6'h10, v); chk("R2 odd write ignored lo", 32'(v), 32'h11);
        rd(6'h12, v); chk("R2 odd write ignored hi", 32'(v), 32'h22);
        for (int i = 0; i < 8; i++) wr(6'(16 + 2 * i), 8'h00);

        // R11: control readback
        wr(6'h22, 8'hFF);
        rd(6'h22, v); chk("R11 control readback", 32'(v), 32'hF7);
        wr(6'h22, 8'h00);
        wr(6'h20, 8'h00);

        // R5: match during settling sets nothing
        wr(6'h10, 8'hB0);
        now_sec = 7'h30;
        idle(3);
        chk("R5 no alarm while settling", 32'(status[0]), 32'h0);
        now_sec = 7'h00;
        settle();
        // R4: edge after settling sets the flag
        now_sec = 7'h30;
        idle(1);
        chk("R4 alarm on match edge", 32'(status[0]), 32'h1);
        wr(6'h20, 8'h00);
        idle(3);
        chk("R4 no re-fire while match holds", 32'(status[0]), 32'h0);

        // R3: hour with PM bit
        wr(6'h10, 8'h00);
        wr(6'h14, 8'hD1);
        now_hour = 7'h11;
        settle();
        idle(1);
        chk("R3 PM bit mismatch", 32'(status[0]), 32'h0);
        now_hour = 7'h51;
        idle(1);
        chk("R3 PM hour match", 32'(status[0]), 32'h1);
        wr(6'h20, 8'h00);
        // R3: no field enabled never matches
        wr(6'h14, 8'h00);
        settle();
        now_hour = 7'h00;
        idle(1);
        now_hour = 7'h51;
        idle(2);
        chk("R3 nothing enabled", 32'(status[0]), 32'h0);
        // R3: year uses its own enable byte
        wr(6'h1C, 8'h24);
        wr(6'h1E, 8'h80);
        now_year = 8'h23;
        settle();
        now_year = 8'h24;
        idle(1);
        chk("R3 year match", 32'(status[0]), 32'h1);
        wr(6'h1E, 8'h00);
        wr(6'h20, 8'h00);

        // R6: rate code 0x8 and a disabled code
        wr(6'h22, 8'h84);
        for (int i = 0; i < 12; i++) step(1'b0, 6'h00, 8'h00, 1'b1, 1'b0);
        wr(6'h22, 8'h34);
        wr(6'h20, 8'h00);
        for (int i = 0; i < 20; i++) step(1'b0, 6'h00, 8'h00, 1'b1, 1'b0);
        chk("R6 low code no events", 32'(status[2]), 32'h0);
        // R10: flag without enable keeps line low
        wr(6'h22, 8'h60);
        for (int i = 0; i < 2; i++) step(1'b0, 6'h00, 8'h00, 1'b1, 1'b0);
        chk("R10 periodic flag set", 32'(status[2]), 32'h1);
        chk("R10 periodic irq masked", 32'(irq_period), 32'h0);

        // R9: set and clear in the same cycle; R8 write-1 keeps
        wr(6'h22, 8'h02);
        step(1'b1, 6'h20, 8'h00, 1'b0, 1'b1);
        chk("R9 carry set beats clear", 32'(status[1]), 32'h1);
        wr(6'h20, 8'hFE);
        chk("R8 write one keeps carry", 32'(status[1]), 32'h1);
        rd(6'h20, v); chk("R8 upper status bits zero", 32'(v[7:3]), 32'h0);
        wr(6'h20, 8'h00);
        chk("R8 write zero clears", 32'(status), 32'h0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit wen, sub, cy;
            logic [5:0] a;
            logic [7:0] d;
            int r, s;
            now_sec  = 7'(tgt[0] ^ 8'($urandom % 2));
            now_min  = 7'(tgt[1] ^ 8'($urandom % 2));
            now_hour = 7'(tgt[2] ^ 8'($urandom % 2));
            now_wday = 3'(tgt[3] ^ 8'($urandom % 2));
            now_day  = 6'(tgt[4] ^ 8'($urandom % 2));
            now_mon  = 5'(tgt[5] ^ 8'($urandom % 2));
            now_year = tgt[6] ^ 8'($urandom % 2);
            r = int'($urandom % 100);
            wen = 1'b0; a = 6'h00; d = 8'h00;
            if (r < 3) begin
                wen = 1'b1;
                s = int'($urandom % 8);
                a = 6'(16 + 2 * s);
                d = (s == 7) ? 8'h00 : tgt[s];
                if ($urandom % 3 == 0) d = d | 8'h80;
            end else if (r < 10) begin
                wen = 1'b1; a = 6'h20; d = 8'($urandom);
            end else if (r < 12) begin
                wen = 1'b1; a = 6'h22; d = 8'($urandom);
            end else if (r < 14) begin
                wen = 1'b1; a = 6'($urandom); d = 8'($urandom);
            end
            sub = ($urandom % 100) < 35;
            cy  = ($urandom % 100) < 4;
            step(wen, a, d, sub, cy);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule